// File: doc/BRIEF.md
# PWM Fault Halt Controller

This block is a safety override that sits between a bank of PWM generators and the output pins. While halting is armed, a qualified edge on an external fault input immediately drives every PWM pin to a safe level chosen per pin. The block does not wait for a PWM period boundary. The override is sticky. It is held in a halt-status bit, and the pins stay forced until software writes that bit back to 0. Software can also halt the outputs on purpose by writing 1 to the same bit.

The fault input is asynchronous. It passes through a two-flop synchronizer and then an edge detector, which can be set to trigger on the rising or the falling edge. The edge detector produces a one-cycle capture pulse. That pulse is brought out to the capture and interrupt logic no matter whether halting is armed or already in effect. The timer that feeds the PWM generators is not touched by a halt, so it keeps running.

Software programs the arm bit, the edge polarity and the per-pin safe levels in a single configuration write. All three read back as written.

Top module: `pwm_fault_halt`

## Requirements
- R1: After reset the halt-status bit, the arm bit, the edge polarity and all safe-level bits are 0. The pins follow the PWM inputs.
- R2: With the arm bit at 0, a capture pulse never sets the halt-status bit.
- R3: With the arm bit at 1, a fault edge that changes the input before clock edge k raises the capture pulse after edge k+1. The halt-status bit is then set, and the pins forced, after edge k+2.
- R4: While halted, pin i equals safe-level bit i. The safe-level bits read back on `force_lvl_o` exactly as they were written.
- R5: While not halted, every output pin equals its PWM input bit.
- R6: The halt-status bit stays set until software writes 0 to it. Removing the fault does not clear it.
- R7: A software write of 1 to the halt-status bit halts the outputs on the next clock edge. This works even with the arm bit at 0 and no fault present.
- R8: When a capture pulse with the arm bit set and a software write of 0 fall in the same cycle, the capture wins and the halt-status bit stays 1.
- R9: `capture_o` is high for exactly one cycle per qualified edge. It pulses whether or not the block is armed or halted.
- R10: Edge polarity 0 qualifies rising fault edges and polarity 1 qualifies falling edges. An edge of the opposite direction produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Loads arm bit, polarity and safe levels |
| cfg_arm_i | input | 1 | Arm bit to load (1 = fault halts outputs) |
| cfg_edge_fall_i | input | 1 | Polarity to load: 0 rising, 1 falling |
| cfg_force_lvl_i | input | N_PINS | Safe levels to load, one bit per pin |
| stat_we_i | input | 1 | Write strobe for the halt-status bit |
| stat_wdata_i | input | 1 | Value written to the halt-status bit |
| fault_i | input | 1 | Asynchronous fault input |
| pwm_i | input | N_PINS | Outputs of the PWM generators |
| pwm_o | output | N_PINS | Pin drive after the override |
| capture_o | output | 1 | One-cycle capture pulse from the fault input |
| halted_o | output | 1 | Halt-status bit |
| arm_o | output | 1 | Read back of the arm bit |
| edge_fall_o | output | 1 | Read back of the polarity |
| force_lvl_o | output | N_PINS | Read back of the safe levels |

## Verification
The hardest situation to reach from the ports is a capture pulse that lands in the same cycle as a software clear. The pulse only appears two edges after the fault input moves, so it is hidden behind the synchronizer. The bench first sets the halt bit by software and arms the block. It then raises the fault input and counts two clock edges. At that point it observes `capture_o` high and drives the clear write in that same cycle, then confirms that the halt bit is still set afterwards. Polarity is checked in both directions, including an opposite-direction edge that must leave the pins untouched.

// File: rtl/pfh_pkg.sv
package pfh_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
endpackage

// File: rtl/pfh_sync.sv
module pfh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pfh_edge_det.sv
module pfh_edge_det
  import pfh_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  input  edge_e sel_i,
  output logic  pulse_o
);
  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    rise    = lvl_i & ~prev_q;
    fall    = ~lvl_i & prev_q;
    pulse_o = (sel_i == EDGE_FALL) ? fall : rise;
  end
endmodule

// File: rtl/pfh_halt_state.sv
module pfh_halt_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic arm_i,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic halted_o
);
  logic halted_q;
  logic halted_d;
  logic trip;

  always_comb begin
    trip     = capture_i & arm_i;
    halted_d = halted_q;
    if (wr_en_i) halted_d = wr_val_i;
    if (trip)    halted_d = 1'b1;  // capture has priority over a clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halted_q <= 1'b0;
    else         halted_q <= halted_d;
  end

  assign halted_o = halted_q;
endmodule

// File: rtl/pfh_out_mux.sv
module pfh_out_mux #(
  parameter int N_PINS = 4
) (
  input  logic              halted_i,
  input  logic [N_PINS-1:0] pwm_i,
  input  logic [N_PINS-1:0] safe_i,
  output logic [N_PINS-1:0] pin_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    assign pin_o[g] = halted_i ? safe_i[g] : pwm_i[g];
  end
endmodule

// File: rtl/pwm_fault_halt.sv
module pwm_fault_halt
  import pfh_pkg::*;
#(
  parameter int N_PINS      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_arm_i,
  input  logic              cfg_edge_fall_i,
  input  logic [N_PINS-1:0] cfg_force_lvl_i,
  input  logic              stat_we_i,
  input  logic              stat_wdata_i,
  input  logic              fault_i,
  input  logic [N_PINS-1:0] pwm_i,
  output logic [N_PINS-1:0] pwm_o,
  output logic              capture_o,
  output logic              halted_o,
  output logic              arm_o,
  output logic              edge_fall_o,
  output logic [N_PINS-1:0] force_lvl_o
);
  localparam int CFG_W = N_PINS + 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_pipe_q[RST_STAGES-1];

  // configuration register with explicit load enable
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we_i) cfg_d = {cfg_arm_i, cfg_edge_fall_i, cfg_force_lvl_i};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  logic  arm;
  edge_e edge_sel;
  logic [N_PINS-1:0] safe_lvl;

  assign arm      = cfg_q[CFG_W-1];
  assign edge_sel = edge_e'(cfg_q[CFG_W-2]);
  assign safe_lvl = cfg_q[N_PINS-1:0];

  logic fault_s;
  logic capture;
  logic halted;

  pfh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (fault_i),
    .q_o    (fault_s)
  );

  pfh_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .lvl_i   (fault_s),
    .sel_i   (edge_sel),
    .pulse_o (capture)
  );

  pfh_halt_state u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .capture_i (capture),
    .arm_i     (arm),
    .wr_en_i   (stat_we_i),
    .wr_val_i  (stat_wdata_i),
    .halted_o  (halted)
  );

  pfh_out_mux #(.N_PINS(N_PINS)) u_mux (
    .halted_i (halted),
    .pwm_i    (pwm_i),
    .safe_i   (safe_lvl),
    .pin_o    (pwm_o)
  );

  assign capture_o   = capture;
  assign halted_o    = halted;
  assign arm_o       = arm;
  assign edge_fall_o = cfg_q[CFG_W-2];
  assign force_lvl_o = safe_lvl;
endmodule

// File: rtl/pfh_checker.sv
module pfh_checker #(
  parameter int N_PINS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stat_we_i,
  input logic              stat_wdata_i,
  input logic [N_PINS-1:0] pwm_i,
  input logic [N_PINS-1:0] pwm_o,
  input logic              capture_o,
  input logic              halted_o,
  input logic              arm_o,
  input logic [N_PINS-1:0] force_lvl_o
);
  p_no_halt_disarmed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_o && !stat_we_i && !halted_o) |=> !halted_o);

  p_capture_halts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && arm_o) |=> halted_o);

  p_forced_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (pwm_o == force_lvl_o));

  p_pass_through_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_o |-> (pwm_o == pwm_i));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !stat_we_i) |=> halted_o);

  p_sw_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && stat_wdata_i) |=> halted_o);

  p_capture_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && arm_o && stat_we_i && !stat_wdata_i) |=> halted_o);

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !capture_o);
endmodule

bind pwm_fault_halt pfh_checker #(.N_PINS(N_PINS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stat_we_i    (stat_we_i),
  .stat_wdata_i (stat_wdata_i),
  .pwm_i        (pwm_i),
  .pwm_o        (pwm_o),
  .capture_o    (capture_o),
  .halted_o     (halted_o),
  .arm_o        (arm_o),
  .force_lvl_o  (force_lvl_o)
);

// File: tb/sim_pwm_fault_halt.sv
`timescale 1ns/1ps
module sim_pwm_fault_halt;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_arm = 1'b0, cfg_fall = 1'b0;
  logic [NP-1:0] cfg_lvl = '0;
  logic          stat_we = 1'b0, stat_wd = 1'b0;
  logic          fault = 1'b0;
  logic [NP-1:0] pwm_in = '0;
  logic [NP-1:0] pwm_out;
  logic          cap, halted, arm, fall_rb;
  logic [NP-1:0] lvl_rb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwm_fault_halt #(.N_PINS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_arm_i(cfg_arm), .cfg_edge_fall_i(cfg_fall),
    .cfg_force_lvl_i(cfg_lvl),
    .stat_we_i(stat_we), .stat_wdata_i(stat_wd),
    .fault_i(fault), .pwm_i(pwm_in),
    .pwm_o(pwm_out), .capture_o(cap), .halted_o(halted),
    .arm_o(arm), .edge_fall_o(fall_rb), .force_lvl_o(lvl_rb)
  );

  // {sw_halt, force levels, pwm input, expected pins}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 4'b1010, 4'b0110, 4'b0110},
    {1'b1, 4'b1010, 4'b0110, 4'b1010},
    {1'b1, 4'b0101, 4'b1111, 4'b0101},
    {1'b0, 4'b0101, 4'b1001, 4'b1001},
    {1'b1, 4'b0000, 4'b1111, 4'b0000},
    {1'b1, 4'b1111, 4'b0000, 4'b1111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic a, input logic f, input logic [NP-1:0] l);
    cfg_we = 1'b1; cfg_arm = a; cfg_fall = f; cfg_lvl = l;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic stat_write(input logic v);
    stat_we = 1'b1; stat_wd = v;
    cyc(1);
    stat_we = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    pwm_in = 4'b1100;
    #1;
    // R1: reset state
    chk("R1 halted", halted, 0);
    chk("R1 arm", arm, 0);
    chk("R1 polarity", fall_rb, 0);
    chk("R1 levels", lvl_rb, 0);
    chk("R1 pins", pwm_out, 4'b1100);

    // table: R4 R5 R7 with software halts, block disarmed
    for (int i = 0; i < 6; i++) begin
      cfg_write(1'b0, 1'b0, VEC[i][11:8]);
      stat_write(VEC[i][12]);
      pwm_in = VEC[i][7:4];
      #1;
      chk("R4 readback", lvl_rb, VEC[i][11:8]);
      chk(VEC[i][12] ? "R7 R4 forced pins" : "R5 pass pins", pwm_out, VEC[i][3:0]);
    end
    stat_write(1'b0);
    #1;
    chk("R6 clear by software", halted, 0);

    // R2: disarmed, rising edge gives capture but no halt
    pwm_in = 4'b0011;
    fault = 1'b1;
    cyc(2); #1;
    chk("R9 capture while disarmed", cap, 1);
    cyc(1); #1;
    chk("R9 one cycle pulse", cap, 0);
    chk("R2 no halt", halted, 0);
    chk("R2 pins pass", pwm_out, 4'b0011);
    fault = 1'b0;
    cyc(4);

    // R3: armed rising edge, exact latency
    cfg_write(1'b1, 1'b0, 4'b1001);
    fault = 1'b1;
    cyc(1); #1;
    chk("R3 no capture after one edge", cap, 0);
    cyc(1); #1;
    chk("R3 capture after two edges", cap, 1);
    chk("R3 not yet halted", halted, 0);
    cyc(1); #1;
    chk("R3 halted after three edges", halted, 1);
    chk("R3 pins forced", pwm_out, 4'b1001);
    fault = 1'b0;
    cyc(5); #1;
    chk("R6 sticky after fault removed", halted, 1);
    chk("R6 pins still forced", pwm_out, 4'b1001);
    stat_write(1'b0);
    #1;
    chk("R6 released", pwm_out, 4'b0011);

    // R8: capture and clear in the same cycle
    stat_write(1'b1);
    fault = 1'b1;
    cyc(2); #1;
    chk("R8 capture present", cap, 1);
    stat_we = 1'b1; stat_wd = 1'b0;
    cyc(1);
    stat_we = 1'b0;
    #1;
    chk("R8 capture wins", halted, 1);
    stat_write(1'b0);
    #1;
    chk("R8 later clear works", halted, 0);

    // R10: falling polarity, fault currently high
    cfg_write(1'b1, 1'b1, 4'b0110);
    #1;
    chk("R10 polarity readback", fall_rb, 1);
    fault = 1'b0;
    cyc(3); #1;
    chk("R10 falling edge halts", halted, 1);
    chk("R10 pins forced", pwm_out, 4'b0110);
    stat_write(1'b0);
    fault = 1'b1;
    cyc(2); #1;
    chk("R10 rising edge ignored capture", cap, 0);
    cyc(2); #1;
    chk("R10 rising edge ignored halt", halted, 0);
    chk("R10 pins pass", pwm_out, 4'b0011);

    // R1: reset in the middle of a halt
    stat_write(1'b1);
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    fault = 1'b0;
    cyc(4); #1;
    chk("R1 reset clears halt", halted, 0);
    chk("R1 reset clears levels", lvl_rb, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule